// File: doc/BRIEF.md
# Floating-Point Environment Save Sequencer

This block copies the architectural environment of a floating-point unit into memory and then masks every floating-point exception. A one-cycle start pulse provides a base address, an image-size selector and a variant selector. The block waits until the arithmetic pipeline reports that it has drained. It then captures the control, status and tag words, the instruction and data pointers and the last opcode. After that it writes the captured image as seven slots through a request/acknowledge memory port.

In 16-bit mode each slot is two bytes, so the image is 14 bytes. In 32-bit mode each slot is four bytes, so the image is 28 bytes. The checking variant looks for pending unmasked exceptions first. If it finds any, it raises a handler request and stores nothing. When the last slot is accepted, the block gives the register file new values for the control word (all exception masks set) and for the status word (condition flags cleared). One cycle later it signals completion.

Top module: `fenv_save_seq`

## Requirements
- R1: After a start pulse, no memory request and no handler request appear while `fpu_idle_i` is low. The environment is captured in the cycle in which `fpu_idle_i` is first seen high. Input changes after that cycle do not alter the written image.
- R2: In 16-bit mode (`wide_i`=0), slot k (k=0..6) is written at base+2k with `mem_wide_o`=0. The slot contents are, in order: control, status, tag, instruction offset[15:0], instruction selector, data offset[15:0], data selector. Bits 31:16 of the data are zero.
- R3: In 32-bit mode (`wide_i`=1), slot k is written at base+4k with `mem_wide_o`=1 and the same slot order. The offsets are written in full 32 bits. Slot 4 carries the selector in bits 15:0 and the 11-bit opcode in bits 26:16. The unused upper bits of all slots are zero.
- R4: While `mem_req_o` is high and `mem_ack_i` is low, the next cycle still has `mem_req_o` high with unchanged address, data and size.
- R5: With `check_i`=1, an exception counts as pending when (status[5:0] AND NOT control[5:0]) is non-zero. A pending exception gives a `handler_req_o` pulse exactly one cycle long. In that case there is no memory request, no `env_upd_o` and no `done_o`.
- R6: With `check_i`=1 and nothing pending, or with `check_i`=0 whatever the flags, the full image is written.
- R7: `env_upd_o` is high only in the cycle in which the seventh slot is acknowledged. `ctrl_new_o` equals the captured control word with bits 5:0 set.
- R8: `stat_new_o` equals the captured status word with the condition bits 8, 9, 10 and 14 cleared.
- R9: `done_o` is high for exactly the one cycle that follows the final acknowledge.
- R10: A start pulse that arrives while an operation is in progress is ignored. The address sequence is not disturbed, and no new operation follows completion.
- R11: During reset and in the first cycle after it, `mem_req_o`, `env_upd_o`, `handler_req_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| check_i | input | 1 | 1 selects the variant that checks for pending exceptions |
| wide_i | input | 1 | 1 selects 32-bit slots, 0 selects 16-bit slots |
| base_addr_i | input | ADDR_W | Byte address of slot 0 |
| fpu_idle_i | input | 1 | Pipeline has drained all earlier operations |
| ctrl_word_i | input | 16 | Live control word |
| stat_word_i | input | 16 | Live status word |
| tag_word_i | input | 16 | Live tag word |
| ip_off_i | input | 32 | Instruction pointer offset |
| ip_sel_i | input | 16 | Instruction pointer selector |
| opcode_i | input | 11 | Last opcode |
| dp_off_i | input | 32 | Data pointer offset |
| dp_sel_i | input | 16 | Data pointer selector |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_wide_o | output | 1 | Write size: 1 means 4 bytes, 0 means 2 bytes |
| mem_ack_i | input | 1 | Write accepted |
| env_upd_o | output | 1 | Load `ctrl_new_o` and `stat_new_o` into the register file |
| ctrl_new_o | output | 16 | Control word with all masks set |
| stat_new_o | output | 16 | Status word with condition flags cleared |
| handler_req_o | output | 1 | Pending-exception handler request pulse |
| done_o | output | 1 | Completion pulse |

## Verification
The first memory request, or the handler request, becomes visible in the cycle after the first sampled `fpu_idle_i`, because the drain state spends one registered cycle before the write or idle state. The bench therefore drives `fpu_idle_i` high on a falling edge and samples on the next falling edge. `env_upd_o` and the new word values follow the acknowledge combinationally in the same cycle, so they are checked just after `mem_ack_i` is driven. `done_o` and the absence of further requests are checked one and more falling edges after the final acknowledge. Every slot is compared with a value the bench builds from its own slot-order function, and stall cycles are compared with the value first seen for that slot.

// File: rtl/fenv_pkg.sv
package fenv_pkg;

    localparam int WORD_W     = 16;
    localparam int OFF_W      = 32;
    localparam int OPC_W      = 11;
    localparam int BUS_W      = 32;
    localparam int EXC_W      = 6;
    localparam int SLOTS      = 7;
    localparam int SLOT_IDX_W = $clog2(SLOTS);

    // condition flag positions 8, 9, 10 and 14 of the status word
    localparam logic [WORD_W-1:0] CC_BITS = 16'h4700;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] tag;
        logic [OFF_W-1:0]  ip_off;
        logic [WORD_W-1:0] ip_sel;
        logic [OPC_W-1:0]  opc;
        logic [OFF_W-1:0]  dp_off;
        logic [WORD_W-1:0] dp_sel;
    } fpu_env_t;

endpackage

// File: rtl/fenv_exc_check.sv
module fenv_exc_check #(
    parameter int EXC_W = 6
) (
    input  logic [EXC_W-1:0] mask_i,
    input  logic [EXC_W-1:0] flag_i,
    output logic             pending_o
);
    logic [EXC_W-1:0] live;

    always_comb begin
        live      = flag_i & ~mask_i;
        pending_o = |live;
    end
endmodule

// File: rtl/fenv_slot_fmt.sv
module fenv_slot_fmt
    import fenv_pkg::*;
(
    input  fpu_env_t              env_i,
    input  logic                  wide_i,
    input  logic [SLOT_IDX_W-1:0] slot_i,
    output logic [BUS_W-1:0]      data_o
);
    localparam int PAD_W = BUS_W - WORD_W;
    localparam int OPC_PAD_W = BUS_W - WORD_W - OPC_W;

    logic [BUS_W-1:0] ip_word;
    logic [BUS_W-1:0] dp_word;
    logic [BUS_W-1:0] sel_opc_word;

    always_comb begin
        ip_word      = wide_i ? env_i.ip_off : {{PAD_W{1'b0}}, env_i.ip_off[WORD_W-1:0]};
        dp_word      = wide_i ? env_i.dp_off : {{PAD_W{1'b0}}, env_i.dp_off[WORD_W-1:0]};
        sel_opc_word = wide_i ? {{OPC_PAD_W{1'b0}}, env_i.opc, env_i.ip_sel}
                              : {{PAD_W{1'b0}}, env_i.ip_sel};
        case (slot_i)
            3'd0:    data_o = {{PAD_W{1'b0}}, env_i.ctrl};
            3'd1:    data_o = {{PAD_W{1'b0}}, env_i.stat};
            3'd2:    data_o = {{PAD_W{1'b0}}, env_i.tag};
            3'd3:    data_o = ip_word;
            3'd4:    data_o = sel_opc_word;
            3'd5:    data_o = dp_word;
            3'd6:    data_o = {{PAD_W{1'b0}}, env_i.dp_sel};
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/fenv_addr_gen.sv
module fenv_addr_gen
    import fenv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [SLOT_IDX_W-1:0] slot_i,
    input  logic                  wide_i,
    output logic [ADDR_W-1:0]     addr_o
);
    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs   = ADDR_W'(slot_i) << (wide_i ? 2 : 1);
        addr_o = base_i + offs;
    end
endmodule

// File: rtl/fenv_save_seq.sv
module fenv_save_seq
    import fenv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic                  check_i,
    input  logic                  wide_i,
    input  logic [ADDR_W-1:0]     base_addr_i,
    input  logic                  fpu_idle_i,
    input  logic [WORD_W-1:0]     ctrl_word_i,
    input  logic [WORD_W-1:0]     stat_word_i,
    input  logic [WORD_W-1:0]     tag_word_i,
    input  logic [OFF_W-1:0]      ip_off_i,
    input  logic [WORD_W-1:0]     ip_sel_i,
    input  logic [OPC_W-1:0]      opcode_i,
    input  logic [OFF_W-1:0]      dp_off_i,
    input  logic [WORD_W-1:0]     dp_sel_i,
    output logic                  mem_req_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [BUS_W-1:0]      mem_wdata_o,
    output logic                  mem_wide_o,
    input  logic                  mem_ack_i,
    output logic                  env_upd_o,
    output logic [WORD_W-1:0]     ctrl_new_o,
    output logic [WORD_W-1:0]     stat_new_o,
    output logic                  handler_req_o,
    output logic                  done_o
);
    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(SLOTS - 1);
    localparam logic [WORD_W-1:0]     MASK_ALL  = WORD_W'((1 << EXC_W) - 1);

    typedef struct packed {
        seq_state_e            state;
        logic [SLOT_IDX_W-1:0] slot;
        logic                  wide;
        logic                  chk;
        logic [ADDR_W-1:0]     base;
        fpu_env_t              env;
        logic                  done;
        logic                  handler;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    fpu_env_t  live_env;
    logic      exc_pending;
    logic      upd_d;

    always_comb begin
        live_env.ctrl   = ctrl_word_i;
        live_env.stat   = stat_word_i;
        live_env.tag    = tag_word_i;
        live_env.ip_off = ip_off_i;
        live_env.ip_sel = ip_sel_i;
        live_env.opc    = opcode_i;
        live_env.dp_off = dp_off_i;
        live_env.dp_sel = dp_sel_i;
    end

    fenv_exc_check #(.EXC_W(EXC_W)) u_exc (
        .mask_i    (ctrl_word_i[EXC_W-1:0]),
        .flag_i    (stat_word_i[EXC_W-1:0]),
        .pending_o (exc_pending)
    );

    fenv_slot_fmt u_fmt (
        .env_i  (regs_q.env),
        .wide_i (regs_q.wide),
        .slot_i (regs_q.slot),
        .data_o (mem_wdata_o)
    );

    fenv_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base_i (regs_q.base),
        .slot_i (regs_q.slot),
        .wide_i (regs_q.wide),
        .addr_o (mem_addr_o)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.done    = 1'b0;
        regs_d.handler = 1'b0;
        upd_d          = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.state = ST_DRAIN;
                    regs_d.wide  = wide_i;
                    regs_d.chk   = check_i;
                    regs_d.base  = base_addr_i;
                end
            end
            ST_DRAIN: begin
                if (fpu_idle_i) begin
                    regs_d.env  = live_env;
                    regs_d.slot = '0;
                    if (regs_q.chk && exc_pending) begin
                        regs_d.handler = 1'b1;
                        regs_d.state   = ST_IDLE;
                    end else begin
                        regs_d.state = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    if (regs_q.slot == LAST_SLOT) begin
                        upd_d        = 1'b1;
                        regs_d.done  = 1'b1;
                        regs_d.state = ST_IDLE;
                    end else begin
                        regs_d.slot = regs_q.slot + 1'b1;
                    end
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        mem_req_o     = (regs_q.state == ST_WRITE);
        mem_wide_o    = regs_q.wide;
        env_upd_o     = upd_d;
        ctrl_new_o    = regs_q.env.ctrl | MASK_ALL;
        stat_new_o    = regs_q.env.stat & ~CC_BITS;
        handler_req_o = regs_q.handler;
        done_o        = regs_q.done;
    end

    // R1
    idle_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_req_o) |-> $past(fpu_idle_i));

    // R4
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_wide_o)));

    // R5
    handler_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        handler_req_o |-> (!mem_req_o && !done_o));

    // R7
    upd_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        env_upd_o |-> (mem_req_o && mem_ack_i));

    // R9
    done_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(env_upd_o));

    // R9
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

// File: tb/fenv_save_seq_test.sv
module fenv_save_seq_test;

    typedef struct packed {
        logic        wide;
        logic        chk;
        logic        poke;
        logic        exp_h;
        logic [15:0] ctrl;
        logic [15:0] stat;
        logic [15:0] tag;
        logic [31:0] ipoff;
        logic [15:0] ipsel;
        logic [10:0] opc;
        logic [31:0] dpoff;
        logic [15:0] dpsel;
        logic [31:0] base;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h037F, 16'h0001, 16'hFFFF, 32'h1234_5678, 16'h0008, 11'h5D9, 32'h9ABC_DEF0, 16'h0010, 32'h0000_0100, 4'd0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'h037F, 16'h3800, 16'h0FF3, 32'hCAFE_0042, 16'h001B, 11'h2A7, 32'h8000_1000, 16'h0023, 32'h0000_2000, 4'd2},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'h037E, 16'h4701, 16'h1234, 32'h0000_1111, 16'h0001, 11'h001, 32'h0000_2222, 16'h0002, 32'h0000_3000, 4'd0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0360, 16'h4700, 16'hA5A5, 32'hFFFF_8001, 16'h7777, 11'h7FF, 32'h5555_AAAA, 16'h4321, 32'h0000_0FFE, 4'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'h0360, 16'h473F, 16'h5A5A, 32'h0BAD_F00D, 16'hBEEF, 11'h3C3, 32'hDEAD_BEEF, 16'h0F0F, 32'h0000_4000, 4'd3},
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'h037B, 16'h0004, 16'h0000, 32'h0000_0001, 16'h0002, 11'h003, 32'h0000_0004, 16'h0005, 32'h0000_5000, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        check_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic        fpu_idle_i = 1'b0;
    logic [15:0] ctrl_word_i = '0;
    logic [15:0] stat_word_i = '0;
    logic [15:0] tag_word_i = '0;
    logic [31:0] ip_off_i = '0;
    logic [15:0] ip_sel_i = '0;
    logic [10:0] opcode_i = '0;
    logic [31:0] dp_off_i = '0;
    logic [15:0] dp_sel_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_wide_o;
    logic        env_upd_o;
    logic [15:0] ctrl_new_o;
    logic [15:0] stat_new_o;
    logic        handler_req_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fenv_save_seq #(.ADDR_W(32)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .check_i(check_i),
        .wide_i(wide_i), .base_addr_i(base_addr_i), .fpu_idle_i(fpu_idle_i),
        .ctrl_word_i(ctrl_word_i), .stat_word_i(stat_word_i), .tag_word_i(tag_word_i),
        .ip_off_i(ip_off_i), .ip_sel_i(ip_sel_i), .opcode_i(opcode_i),
        .dp_off_i(dp_off_i), .dp_sel_i(dp_sel_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_wide_o(mem_wide_o), .mem_ack_i(mem_ack_i), .env_upd_o(env_upd_o),
        .ctrl_new_o(ctrl_new_o), .stat_new_o(stat_new_o),
        .handler_req_o(handler_req_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_slot(input vec_t v, input int k);
        case (k)
            0: return {16'h0, v.ctrl};
            1: return {16'h0, v.stat};
            2: return {16'h0, v.tag};
            3: return v.wide ? v.ipoff : {16'h0, v.ipoff[15:0]};
            4: return v.wide ? {5'h0, v.opc, v.ipsel} : {16'h0, v.ipsel};
            5: return v.wide ? v.dpoff : {16'h0, v.dpoff[15:0]};
            default: return {16'h0, v.dpsel};
        endcase
    endfunction

    task automatic drive_env(input vec_t v, input logic scramble);
        ctrl_word_i = scramble ? ~v.ctrl  : v.ctrl;
        stat_word_i = scramble ? ~v.stat  : v.stat;
        tag_word_i  = scramble ? ~v.tag   : v.tag;
        ip_off_i    = scramble ? ~v.ipoff : v.ipoff;
        ip_sel_i    = scramble ? ~v.ipsel : v.ipsel;
        opcode_i    = scramble ? ~v.opc   : v.opc;
        dp_off_i    = scramble ? ~v.dpoff : v.dpoff;
        dp_sel_i    = scramble ? ~v.dpsel : v.dpsel;
    endtask

    task automatic run_vec(input vec_t v);
        int slot = 0;
        int waited = 0;
        logic got_h = 1'b0;
        logic fin = 1'b0;
        logic adv;
        logic [31:0] pa = '0;
        logic [31:0] pd = '0;
        logic [31:0] ea;
        string rq;

        rq = v.wide ? "R3" : "R2";
        @(negedge clk);
        drive_env(v, 1'b0);
        start_i = 1'b1; check_i = v.chk; wide_i = v.wide; base_addr_i = v.base;
        fpu_idle_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        wide_i = ~v.wide;
        base_addr_i = 32'hFFFF_0000;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            // R1: nothing issues before the drain indication
            check("R1", !mem_req_o && !handler_req_o, {mem_req_o, handler_req_o}, 0);
        end
        fpu_idle_i = 1'b1;
        @(negedge clk);
        drive_env(v, 1'b1);  // R1: late changes must not reach the image
        for (int c = 0; c < 80 && !fin; c++) begin
            adv = 1'b0;
            if (handler_req_o) begin
                got_h = 1'b1;
                fin = 1'b1;
            end else if (mem_req_o) begin
                if (waited == 0) begin
                    pa = mem_addr_o; pd = mem_wdata_o;
                end else begin
                    // R4: stalled request holds its contents
                    check("R4", mem_addr_o == pa && mem_wdata_o == pd, mem_wdata_o, pd);
                end
                if (waited < int'(v.lat)) begin
                    waited++;
                end else begin
                    ea = v.base + slot * (v.wide ? 4 : 2);
                    check(rq, mem_addr_o == ea, mem_addr_o, ea);
                    check(rq, mem_wdata_o == exp_slot(v, slot), mem_wdata_o, exp_slot(v, slot));
                    check(rq, mem_wide_o == v.wide, mem_wide_o, v.wide);
                    mem_ack_i = 1'b1;
                    if (v.poke && slot == 2) start_i = 1'b1;  // R10
                    #1;
                    if (slot == 6) begin
                        check("R7", env_upd_o == 1'b1, env_upd_o, 1);
                        check("R7", ctrl_new_o == (v.ctrl | 16'h003F), ctrl_new_o, v.ctrl | 16'h003F);
                        check("R8", stat_new_o == (v.stat & 16'hB8FF), stat_new_o, v.stat & 16'hB8FF);
                    end else begin
                        check("R7", env_upd_o == 1'b0, env_upd_o, 0);
                    end
                    @(negedge clk);
                    adv = 1'b1;
                    mem_ack_i = 1'b0;
                    start_i = 1'b0;
                    slot++;
                    waited = 0;
                    if (slot == 7) begin
                        check("R9", done_o == 1'b1, done_o, 1);
                        fin = 1'b1;
                    end
                end
            end
            if (!adv && !fin) @(negedge clk);
        end
        check(v.exp_h ? "R5" : "R6", got_h == v.exp_h, got_h, v.exp_h);
        check(v.exp_h ? "R5" : "R6", slot == (v.exp_h ? 0 : 7), slot, v.exp_h ? 0 : 7);
        @(negedge clk);
        if (v.exp_h) begin
            check("R5", handler_req_o == 1'b0, handler_req_o, 0);
        end else begin
            check("R9", done_o == 1'b0, done_o, 0);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(v.poke ? "R10" : (v.exp_h ? "R5" : "R6"),
                  !mem_req_o && !env_upd_o && !done_o, {mem_req_o, env_upd_o, done_o}, 0);
        end
        fpu_idle_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R11: quiet during reset
            check("R11", !mem_req_o && !env_upd_o && !handler_req_o && !done_o,
                  {mem_req_o, env_upd_o, handler_req_o, done_o}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", !mem_req_o && !handler_req_o && !done_o, {mem_req_o, handler_req_o, done_o}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R11: reset mid-operation returns to quiet state
        @(negedge clk);
        drive_env(VECS[0], 1'b0);
        start_i = 1'b1; wide_i = 1'b0; check_i = 1'b0; base_addr_i = 32'h0;
        fpu_idle_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R2", mem_req_o == 1'b1, mem_req_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", !mem_req_o && !done_o, {mem_req_o, done_o}, 0);
        rst_n = 1'b1;
        fpu_idle_i = 1'b0;
        @(negedge clk);
        check("R11", !mem_req_o && !handler_req_o, {mem_req_o, handler_req_o}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule